// File: doc/BRIEF.md
# Prioritized Interrupt Vectoring Unit

This block turns a set of five latched interrupt request lines into a complete interrupt entry. It waits for an instruction boundary while the global interrupt enable is set and at least one request is pending. It then picks the winning request from a fixed priority order, clears the global enable and saves the address of the next instruction. That address is pushed onto a stack in RAM as three 4-bit nibbles through a narrow write port, and the program counter is then loaded with the winner's vector.

Vectors sit on a fixed code page at 0x100. Only the low nibble of the new program counter depends on the request, so the sources land on 0x102, 0x104, 0x106, 0x108 and 0x10A. The whole entry takes a fixed twelve cycles. On the last of those cycles the block pulses a one-hot acknowledge so that the winning source can drop its flag. Requests that lost stay pending and compete again once software re-enables interrupts.

Top module: `irq_vector_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy_o, ien_clr_o, sp_dec_o, mem_we_o and pc_load_o are 0 and ack_o is all zeros.
- R2: An entry starts (busy_o rises on the next clock edge) only when the block is idle and, at that edge, instr_done_i = 1, ien_i = 1 and req_i is non-zero. Without all three, busy_o stays 0.
- R3: Request bit 0 (remote control receiver) has the highest priority, followed by bit 1 (frequency converter), bit 2 (upper key port) and bit 3 (lower key port). Bit 4 (clock timer) has the lowest. The lowest-numbered pending bit wins.
- R4: On the load cycle, pc_new_o = 0x100 + 2*(k+1) for winning bit k. The upper eight bits are always 0x10.
- R5: The captured pc_i is pushed as three nibbles in the order bits [11:8], [7:4], [3:0], at addresses sp-1, sp-2 and sp-3, where sp is the sp_i captured at the start. Each write cycle (mem_we_o = 1) comes directly after a one-cycle sp_dec_o pulse. The pulses occur in busy cycles 2, 5 and 8, and the writes in busy cycles 3, 6 and 9.
- R6: busy_o stays high for exactly 12 cycles. pc_load_o is 1 only in the 12th of them.
- R7: ack_o is one-hot on the winning bit, only in the pc_load_o cycle, and zero in every other cycle.
- R8: ien_clr_o pulses for one cycle, in the first busy cycle.
- R9: Pending requests that lose are not acknowledged. They are taken in priority order in later entries once ien_i is set again.
- R10: Changes on req_i, pc_i and sp_i during an entry do not change its winner, vector, pushed data or push addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Latched interrupt requests, bit 0 highest priority |
| ien_i | input | 1 | Global interrupt enable flag |
| instr_done_i | input | 1 | Current instruction has completed |
| pc_i | input | 12 | Address of the next instruction |
| sp_i | input | 8 | Current stack pointer |
| busy_o | output | 1 | Entry sequence in progress |
| ien_clr_o | output | 1 | Pulse that clears the global enable |
| sp_dec_o | output | 1 | Stack pointer decrement pulse |
| mem_we_o | output | 1 | Stack RAM write strobe |
| mem_addr_o | output | 8 | Stack RAM write address |
| mem_wdata_o | output | 4 | Stack RAM write nibble |
| pc_load_o | output | 1 | Load pc_new_o into the program counter |
| pc_new_o | output | 12 | Vector address, valid with pc_load_o |
| ack_o | output | 5 | One-hot acknowledge of the serviced source |

## Verification
The assertions assume that reset is held for at least one clock edge and that all inputs are known at every clock edge. They also assume that the stack pointer captured at entry is at least three, so the push addresses never wrap below zero. The bench changes inputs only at falling edges. Every sp_i it drives is well above three. It acts as software: it drops ien_i when the clear pulse appears and drops the acknowledged request bit. Some requests are deliberately raised and operands changed mid-entry, and the checks confirm that these values are ignored rather than that they are absent.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   typedef enum logic [2:0] {
      STEP_IDLE,
      STEP_CLR,
      STEP_DEC,
      STEP_WR,
      STEP_WAIT,
      STEP_JUMP
   } step_e;

   function automatic int nsel_width(input int nibbles);
      return (nibbles > 1) ? $clog2(nibbles) : 1;
   endfunction
endpackage

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
   parameter int N_SRC       = 5,
   parameter bit HIGH_AT_LSB = 1'b1,
   localparam int IDX_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   assign any = |req;

   generate
      if (HIGH_AT_LSB) begin : g_lsb_first
         always_comb begin
            idx = '0;
            for (int i = N_SRC - 1; i >= 0; i--) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end else begin : g_msb_first
         always_comb begin
            idx = '0;
            for (int i = 0; i < N_SRC; i++) begin
               if (req[i]) idx = IDX_W'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irqv_seq.sv
module irqv_seq
   import irqv_pkg::*;
#(
   parameter int ENTRY_CYCLES = 12,
   parameter int NIBBLES      = 3,
   localparam int CNT_W       = $clog2(ENTRY_CYCLES),
   localparam int NSEL_W      = nsel_width(NIBBLES),
   localparam int LAST        = ENTRY_CYCLES - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output step_e             step,
   output logic [NSEL_W-1:0] nib_sel
);
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         if (cnt_q == CNT_W'(LAST)) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (start) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end
   end

   assign busy = busy_q;

   always_comb begin
      step    = STEP_IDLE;
      nib_sel = '0;
      if (busy_q) begin
         step = STEP_WAIT;
         if (cnt_q == '0) step = STEP_CLR;
         for (int i = 0; i < NIBBLES; i++) begin
            if (cnt_q == CNT_W'(3 * i + 1)) step = STEP_DEC;
            if (cnt_q == CNT_W'(3 * i + 2)) begin
               step    = STEP_WR;
               nib_sel = NSEL_W'(i);
            end
         end
         if (cnt_q == CNT_W'(LAST)) step = STEP_JUMP;
      end
   end
endmodule

// File: rtl/irqv_push.sv
module irqv_push
   import irqv_pkg::*;
#(
   parameter int PC_W    = 12,
   parameter int NIB_W   = 4,
   parameter int SP_W    = 8,
   localparam int NIBBLES = PC_W / NIB_W,
   localparam int NSEL_W  = nsel_width(NIBBLES)
) (
   input  logic              wr,
   input  logic [NSEL_W-1:0] nib_sel,
   input  logic [PC_W-1:0]   pc_cap,
   input  logic [SP_W-1:0]   sp_cap,
   output logic [SP_W-1:0]   addr,
   output logic [NIB_W-1:0]  data
);
   logic [NIB_W-1:0] nib_mux;

   always_comb begin
      nib_mux = '0;
      for (int i = 0; i < NIBBLES; i++) begin
         if (nib_sel == NSEL_W'(i)) nib_mux = pc_cap[PC_W-1-i*NIB_W -: NIB_W];
      end
   end

   assign addr = wr ? (sp_cap - SP_W'(nib_sel) - SP_W'(1)) : '0;
   assign data = wr ? nib_mux : '0;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
   import irqv_pkg::*;
#(
   parameter int N_SRC        = 5,
   parameter int PC_W         = 12,
   parameter int NIB_W        = 4,
   parameter int SP_W         = 8,
   parameter int ENTRY_CYCLES = 12,
   parameter int VEC_BASE     = 'h100,
   parameter int VEC_FIRST    = 2,
   parameter int VEC_STEP     = 2,
   parameter bit HIGH_AT_LSB  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  req_i,
   input  logic              ien_i,
   input  logic              instr_done_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [SP_W-1:0]   sp_i,
   output logic              busy_o,
   output logic              ien_clr_o,
   output logic              sp_dec_o,
   output logic              mem_we_o,
   output logic [SP_W-1:0]   mem_addr_o,
   output logic [NIB_W-1:0]  mem_wdata_o,
   output logic              pc_load_o,
   output logic [PC_W-1:0]   pc_new_o,
   output logic [N_SRC-1:0]  ack_o
);
   localparam int NIBBLES = PC_W / NIB_W;
   localparam int NSEL_W  = nsel_width(NIBBLES);
   localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam int VEC_TOP = VEC_FIRST + (N_SRC - 1) * VEC_STEP;

   generate
      if (PC_W % NIB_W != 0) begin : g_bad_nib
         $error("PC_W must be a multiple of NIB_W");
      end
      if (ENTRY_CYCLES < 3 * NIBBLES + 1) begin : g_bad_len
         $error("ENTRY_CYCLES too short for the push sequence");
      end
      if (VEC_TOP >= (1 << NIB_W)) begin : g_bad_vec
         $error("vector offsets do not fit in the low nibble");
      end
      if ((VEC_BASE % (1 << NIB_W)) != 0) begin : g_bad_base
         $error("VEC_BASE must have a zero low nibble");
      end
   endgenerate

   logic              any_req;
   logic [IDX_W-1:0]  win_idx;
   logic              start;
   logic              busy;
   step_e             step;
   logic [NSEL_W-1:0] nib_sel;
   logic [IDX_W-1:0]  win_q;
   logic [PC_W-1:0]   pc_q;
   logic [SP_W-1:0]   sp_q;
   logic [NIB_W-1:0]  vec_low;

   irqv_prio_enc #(
      .N_SRC       (N_SRC),
      .HIGH_AT_LSB (HIGH_AT_LSB)
   ) u_enc (
      .req (req_i),
      .any (any_req),
      .idx (win_idx)
   );

   assign start = !busy && instr_done_i && ien_i && any_req;

   irqv_seq #(
      .ENTRY_CYCLES (ENTRY_CYCLES),
      .NIBBLES      (NIBBLES)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .busy    (busy),
      .step    (step),
      .nib_sel (nib_sel)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q <= '0;
         pc_q  <= '0;
         sp_q  <= '0;
      end else if (start) begin
         win_q <= win_idx;
         pc_q  <= pc_i;
         sp_q  <= sp_i;
      end
   end

   irqv_push #(
      .PC_W  (PC_W),
      .NIB_W (NIB_W),
      .SP_W  (SP_W)
   ) u_push (
      .wr      (mem_we_o),
      .nib_sel (nib_sel),
      .pc_cap  (pc_q),
      .sp_cap  (sp_q),
      .addr    (mem_addr_o),
      .data    (mem_wdata_o)
   );

   assign vec_low   = NIB_W'(VEC_FIRST + VEC_STEP * int'(win_q));
   assign busy_o    = busy;
   assign ien_clr_o = (step == STEP_CLR);
   assign sp_dec_o  = (step == STEP_DEC);
   assign mem_we_o  = (step == STEP_WR);
   assign pc_load_o = (step == STEP_JUMP);
   assign pc_new_o  = pc_load_o ? (PC_W'(VEC_BASE) | PC_W'(vec_low)) : '0;

   generate
      for (genvar g = 0; g < N_SRC; g++) begin : g_ack
         assign ack_o[g] = pc_load_o && (win_q == IDX_W'(g));
      end
   endgenerate
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
   parameter int N_SRC        = 5,
   parameter int PC_W         = 12,
   parameter int ENTRY_CYCLES = 12,
   parameter int VEC_BASE     = 'h100
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_SRC-1:0] req_i,
   input logic             ien_i,
   input logic             instr_done_i,
   input logic             busy_o,
   input logic             ien_clr_o,
   input logic             sp_dec_o,
   input logic             mem_we_o,
   input logic             pc_load_o,
   input logic [PC_W-1:0]  pc_new_o,
   input logic [N_SRC-1:0] ack_o
);
   localparam int LEN_W = $clog2(ENTRY_CYCLES + 1);
   logic [LEN_W-1:0] run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) run_len <= '0;
      else if (busy_o) run_len <= run_len + 1'b1;
      else run_len <= '0;
   end

   AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(instr_done_i && ien_i && (req_i != '0))); // R2
   AST_VEC_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |-> (pc_new_o[PC_W-1:4] == PC_W'(VEC_BASE) >> 4)); // R4
   AST_WRITE_AFTER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $past(sp_dec_o)); // R5
   AST_LOAD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load_o |-> (run_len == LEN_W'(ENTRY_CYCLES - 1))); // R6
   AST_FIXED_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(pc_load_o)); // R6
   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_o)); // R7
   AST_ACK_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o != '0) == pc_load_o); // R7
   AST_CLR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      ien_clr_o |-> $rose(busy_o)); // R8
endmodule

bind irq_vector_unit irqv_checker #(
   .N_SRC        (N_SRC),
   .PC_W         (PC_W),
   .ENTRY_CYCLES (ENTRY_CYCLES),
   .VEC_BASE     (VEC_BASE)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .ien_i        (ien_i),
   .instr_done_i (instr_done_i),
   .busy_o       (busy_o),
   .ien_clr_o    (ien_clr_o),
   .sp_dec_o     (sp_dec_o),
   .mem_we_o     (mem_we_o),
   .pc_load_o    (pc_load_o),
   .pc_new_o     (pc_new_o),
   .ack_o        (ack_o)
);

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  req_r = '0;
   logic        ien_r = 1'b0;
   logic        done_r = 1'b0;
   logic [11:0] pc_r = '0;
   logic [7:0]  sp_r = 8'h40;
   logic        busy_o, ien_clr_o, sp_dec_o, mem_we_o, pc_load_o;
   logic [7:0]  mem_addr_o;
   logic [3:0]  mem_wdata_o;
   logic [11:0] pc_new_o;
   logic [4:0]  ack_o;

   always #10 clk = ~clk;

   irq_vector_unit dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_r), .ien_i(ien_r),
      .instr_done_i(done_r), .pc_i(pc_r), .sp_i(sp_r),
      .busy_o(busy_o), .ien_clr_o(ien_clr_o), .sp_dec_o(sp_dec_o),
      .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .pc_load_o(pc_load_o), .pc_new_o(pc_new_o), .ack_o(ack_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit hung = 0;

   // behavioural reference state
   bit m_busy = 0;
   int m_cnt = 0;
   int m_win = 0;
   int m_pc = 0;
   int m_sp = 0;

   logic [3:0] ram [256];
   int dec_seen, clr_seen, busy_len, last_pc, last_ack;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 0;
         m_cnt  <= 0;
      end else if (m_busy) begin
         if (m_cnt == 11) m_busy <= 0;
         else m_cnt <= m_cnt + 1;
      end else if (done_r && ien_r && req_r != 0) begin
         m_busy <= 1;
         m_cnt  <= 0;
         for (int i = 4; i >= 0; i--) if (req_r[i]) m_win <= i;
         m_pc <= int'(pc_r);
         m_sp <= int'(sp_r);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      bit e_clr, e_dec, e_we, e_load;
      int k;
      @(negedge clk);
      cyc++;
      e_clr  = m_busy && m_cnt == 0;
      e_dec  = m_busy && (m_cnt == 1 || m_cnt == 4 || m_cnt == 7);
      e_we   = m_busy && (m_cnt == 2 || m_cnt == 5 || m_cnt == 8);
      e_load = m_busy && m_cnt == 11;
      chk("R6 busy", int'(busy_o), int'(m_busy));
      chk("R8 ien_clr", int'(ien_clr_o), int'(e_clr));
      chk("R5 sp_dec", int'(sp_dec_o), int'(e_dec));
      chk("R5 mem_we", int'(mem_we_o), int'(e_we));
      chk("R6 pc_load", int'(pc_load_o), int'(e_load));
      chk("R7 ack", int'(ack_o), e_load ? (1 << m_win) : 0);
      if (e_we) begin
         k = (m_cnt - 2) / 3;
         chk("R5 addr", int'(mem_addr_o), (m_sp - k - 1) & 8'hFF);
         chk("R5 data", int'(mem_wdata_o), (m_pc >> (8 - 4 * k)) & 4'hF);
      end
      if (e_load) chk("R4 vector", int'(pc_new_o), 'h100 + 2 * (m_win + 1));
      if (mem_we_o) ram[mem_addr_o] = mem_wdata_o;
      if (sp_dec_o) dec_seen++;
      if (ien_clr_o) begin clr_seen++; ien_r = 1'b0; end
      if (busy_o) busy_len++;
      if (pc_load_o) begin last_pc = int'(pc_new_o); last_ack = int'(ack_o); end
      if (ack_o != 0) req_r = req_r & ~ack_o;
      if (cyc > 20000 && !hung) begin
         hung = 1;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected<20000", cyc);
      end
   endtask

   task automatic run_seq(input bit disturb);
      int lim;
      dec_seen = 0; clr_seen = 0; busy_len = 0; last_pc = 0; last_ack = 0;
      lim = 0;
      while (!busy_o && lim < 50 && !hung) begin tick(); lim++; end
      if (disturb) begin
         tick(); tick();
         pc_r  = 12'hFFF;
         sp_r  = 8'h80;
         req_r = req_r | 5'b00001;
      end
      while (busy_o && !hung) tick();
   endtask

   initial begin
      repeat (3) begin
         tick();
         chk("R1 reset outputs",
             int'({busy_o, ien_clr_o, sp_dec_o, mem_we_o, pc_load_o, ack_o}), 0);
      end
      rst_n = 1'b1;
      tick();
      chk("R1 after reset busy", int'(busy_o), 0);

      // R2: missing enable or missing boundary blocks entry
      req_r = 5'b10000; done_r = 1'b1; ien_r = 1'b0;
      repeat (5) tick();
      chk("R2 no entry with ien low", int'(busy_o), 0);
      ien_r = 1'b1; done_r = 1'b0;
      repeat (5) tick();
      chk("R2 no entry without boundary", int'(busy_o), 0);

      // lowest-priority source alone
      pc_r = 12'h3A5; sp_r = 8'h40; done_r = 1'b1;
      run_seq(1'b0);
      chk("R4 timer vector", last_pc, 'h10A);
      chk("R3 timer ack", last_ack, 5'b10000);
      chk("R5 ram hi", int'(ram[8'h3F]), 'h3);
      chk("R5 ram mid", int'(ram[8'h3E]), 'hA);
      chk("R5 ram lo", int'(ram[8'h3D]), 'h5);
      chk("R5 dec count", dec_seen, 3);
      chk("R6 busy length", busy_len, 12);
      chk("R8 clr count", clr_seen, 1);
      chk("R8 ien dropped", int'(ien_r), 0);
      repeat (3) tick();
      chk("R2 no re-entry while ien low", int'(busy_o), 0);

      // three pending: served in priority order
      pc_r = 12'h7C1; sp_r = 8'h20; req_r = 5'b01110; ien_r = 1'b1;
      run_seq(1'b0);
      chk("R3 frequency converter wins", last_pc, 'h104);
      chk("R9 losers still pending", int'(req_r), 5'b01100);
      ien_r = 1'b1;
      run_seq(1'b0);
      chk("R9 upper key next", last_pc, 'h106);
      ien_r = 1'b1;
      run_seq(1'b0);
      chk("R9 lower key last", last_pc, 'h108);
      chk("R7 lower key ack", last_ack, 5'b01000);

      // inputs disturbed mid-entry
      pc_r = 12'h5E3; sp_r = 8'h30; req_r = 5'b00100; ien_r = 1'b1;
      run_seq(1'b1);
      chk("R10 winner kept", last_pc, 'h106);
      chk("R10 ram hi", int'(ram[8'h2F]), 'h5);
      chk("R10 ram mid", int'(ram[8'h2E]), 'hE);
      chk("R10 ram lo", int'(ram[8'h2D]), 'h3);
      chk("R10 late request pending", int'(req_r), 5'b00001);
      ien_r = 1'b1;
      run_seq(1'b0);
      chk("R3 remote control vector", last_pc, 'h102);
      chk("R7 remote control ack", last_ack, 5'b00001);
      repeat (3) tick();

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule